// File: doc/BRIEF.md
# Partial Carry-Save Booth Multiplier

This block multiplies two signed operands that both arrive in partial carry-save form. Each operand is a 16-bit two's-complement main word plus a sparse vector of pending carries, one bit per 4-bit fragment. Each carry bit sits at the low column of its fragment. The block returns its product in the same kind of redundant form. That form is a 32-bit word plus one pending carry per 4-bit fragment of that word. The product can therefore feed a datapath of speculative adders without first being resolved.

The pending carries of the multiplier operand are absorbed when the operation is accepted. The main word and the carries are summed into an 18-bit value. That value is recoded into nine radix-4 Booth digits in {-2,-1,0,+1,+2}. A small state machine then takes one digit per cycle. For each digit it forms two shifted multiples: one of the multiplicand's main word and one of its carry vector. A 4:2 compressor folds both multiples into a sum/carry accumulator. Rows with a negative digit are built by bitwise inversion. Their missing +1 terms are gathered into one vector that seeds the accumulator at load time. A fragmented adder closes the operation. It adds the two accumulator vectors with each 4-bit fragment's carry-in guessed as zero, and reports every fragment carry-out as a pending carry of the next fragment.

The states are S_IDLE, S_ACCUM and S_RESOLVE. The transitions are:
- S_IDLE to S_ACCUM when start is sampled high.
- S_ACCUM to itself while Booth rows remain.
- S_ACCUM to S_RESOLVE after the last row.
- S_RESOLVE to S_IDLE unconditionally, publishing the result.

Top module: `pcs_booth_mul`

## Requirements
- R1: An operand's value is the signed main word plus the sum over j of its fragment bit j times 2^(4j), for j = 0..3. This sum is taken exactly, not wrapped to 16 bits.
- R2: When p_valid is high, p_word plus the sum over j of p_frag[j] times 2^(4j), for j = 0..7, equals the product of the two operand values taken modulo 2^32.
- R3: p_frag[0] is always 0, because the lowest output fragment has a zero carry-in.
- R4: p_valid is high exactly 10 clock edges after the edge that sampled an accepted start, and at no other time.
- R5: p_valid is a single-cycle pulse.
- R6: start sampled while an operation is in flight (S_ACCUM or S_RESOLVE) is ignored. It produces no extra result and does not alter the result in flight.
- R7: p_word and p_frag change only in the cycle p_valid rises, and hold the last result otherwise.
- R8: After reset, p_valid, p_word and p_frag are all zero.
- R9: start high in the cycle p_valid is high is accepted, so operations can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a product; sampled only in S_IDLE |
| a_word | input | 16 | Multiplicand main word, two's complement |
| a_frag | input | 4 | Multiplicand pending carries, bit j weighs 2^(4j) |
| b_word | input | 16 | Multiplier main word, two's complement |
| b_frag | input | 4 | Multiplier pending carries, bit j weighs 2^(4j) |
| p_valid | output | 1 | One-cycle pulse marking a new product |
| p_word | output | 32 | Product main word |
| p_frag | output | 8 | Product pending carries, bit j weighs 2^(4j) |

## Verification
A wrong row counter or state register shows up at once as a p_valid pulse that is missing, early or late relative to the 10-edge mark. It also shows up as a start that is accepted while busy.

A corrupted accumulator, Booth digit, seed bit or negation appears only in the resolved product. That product becomes visible at the next p_valid pulse, up to 10 cycles after the fault.

Faults in the output register enable show up as p_word or p_frag moving between pulses.

Random operands with sparse carries, extreme values and streams of starts held high expose all three kinds of fault.

// File: rtl/pcs_mul_pkg.sv
package pcs_mul_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ACCUM,
        S_RESOLVE
    } mul_state_e;

    // One radix-4 Booth digit: sign and magnitude selection
    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } booth_dig_t;

    // Recode a bit triplet {y[2i+1], y[2i], y[2i-1]}
    function automatic booth_dig_t booth_decode(input logic [2:0] trip);
        booth_dig_t d;
        case (trip)
            3'b001, 3'b010: d = '{neg: 1'b0, one: 1'b1, two: 1'b0};
            3'b011:         d = '{neg: 1'b0, one: 1'b0, two: 1'b1};
            3'b100:         d = '{neg: 1'b1, one: 1'b0, two: 1'b1};
            3'b101, 3'b110: d = '{neg: 1'b1, one: 1'b1, two: 1'b0};
            default:        d = '{neg: 1'b0, one: 1'b0, two: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pcs_booth_row.sv
module pcs_booth_row
    import pcs_mul_pkg::*;
#(
    parameter int W  = 32,
    parameter int RW = 4
) (
    input  logic [2:0]    trip,
    input  logic [RW-1:0] row,
    input  logic [W-1:0]  xm,
    input  logic [W-1:0]  xc,
    output logic [W-1:0]  pm,
    output logic [W-1:0]  pc
);

    booth_dig_t   dig;
    logic [W-1:0] mag_m, mag_c;
    logic [W-1:0] sel_m, sel_c;
    logic [RW:0]  shamt;

    assign dig   = booth_decode(trip);
    assign shamt = {row, 1'b0};

    always_comb begin
        mag_m = '0;
        mag_c = '0;
        if (dig.two) begin
            mag_m = xm << 1;
            mag_c = xc << 1;
        end else if (dig.one) begin
            mag_m = xm;
            mag_c = xc;
        end
        // Inversion only; the +1 per inverted vector is pre-seeded in the accumulator
        sel_m = dig.neg ? ~mag_m : mag_m;
        sel_c = dig.neg ? ~mag_c : mag_c;
    end

    assign pm = sel_m << shamt;
    assign pc = sel_c << shamt;

endmodule

// File: rtl/pcs_csa42.sv
module pcs_csa42 #(
    parameter int W = 32
) (
    input  logic [W-1:0] in0,
    input  logic [W-1:0] in1,
    input  logic [W-1:0] in2,
    input  logic [W-1:0] in3,
    output logic [W-1:0] sum,
    output logic [W-1:0] cry
);

    logic [W-1:0] lat;
    logic [W-2:0] kout;

    assign lat[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_col
        logic t1;
        assign t1     = in0[i] ^ in1[i] ^ in2[i];
        assign sum[i] = t1 ^ in3[i] ^ lat[i];
        if (i < W - 1) begin : g_chain
            assign lat[i+1] = (in0[i] & in1[i]) | (in0[i] & in2[i]) | (in1[i] & in2[i]);
            assign kout[i]  = (t1 & in3[i]) | (t1 & lat[i]) | (in3[i] & lat[i]);
        end
    end

    assign cry = {kout, 1'b0};

endmodule

// File: rtl/pcs_frag_adder.sv
module pcs_frag_adder #(
    parameter int W = 32,
    parameter int K = 4
) (
    input  logic [W-1:0]   op_s,
    input  logic [W-1:0]   op_c,
    output logic [W-1:0]   sum,
    output logic [W/K-1:0] fcy
);

    localparam int NF = W / K;

    assign fcy[0] = 1'b0;

    for (genvar f = 0; f < NF; f++) begin : g_frag
        if (f < NF - 1) begin : g_mid
            logic [K:0] part;
            assign part           = {1'b0, op_s[f*K +: K]} + {1'b0, op_c[f*K +: K]};
            assign sum[f*K +: K]  = part[K-1:0];
            assign fcy[f+1]       = part[K];
        end else begin : g_top
            assign sum[f*K +: K] = op_s[f*K +: K] + op_c[f*K +: K];
        end
    end

endmodule

// File: rtl/pcs_booth_mul.sv
module pcs_booth_mul
    import pcs_mul_pkg::*;
#(
    parameter int N = 16,
    parameter int K = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [N-1:0]     a_word,
    input  logic [N/K-1:0]   a_frag,
    input  logic [N-1:0]     b_word,
    input  logic [N/K-1:0]   b_frag,
    output logic             p_valid,
    output logic [2*N-1:0]   p_word,
    output logic [2*N/K-1:0] p_frag
);

    localparam int W      = 2 * N;
    localparam int NF_IN  = N / K;
    localparam int NF_OUT = W / K;
    localparam int YW     = N + 2;
    localparam int ROWS   = YW / 2;
    localparam int RW     = $clog2(ROWS);

    mul_state_e state, state_nx;

    logic [RW-1:0] row_q;
    logic [YW-1:0] ymul_q;
    logic [W-1:0]  xm_q, xc_q;
    logic [W-1:0]  acc_s, acc_c;

    // Load-time operand preparation
    logic [YW-1:0] b_spread, y_in;
    logic [YW:0]   y_in_ext;
    logic [W-1:0]  a_spread, a_ext, seed;

    always_comb begin
        a_spread = '0;
        b_spread = '0;
        for (int j = 0; j < NF_IN; j++) begin
            a_spread[j*K] = a_frag[j];
            b_spread[j*K] = b_frag[j];
        end
    end

    assign a_ext    = {{(W-N){a_word[N-1]}}, a_word};
    assign y_in     = {{(YW-N){b_word[N-1]}}, b_word} + b_spread;
    assign y_in_ext = {y_in, 1'b0};

    // Two +1 terms per negated row (main and carry multiples) gathered at column 2i+1
    always_comb begin
        booth_dig_t d;
        seed = '0;
        for (int i = 0; i < ROWS; i++) begin
            d = booth_decode(y_in_ext[2*i +: 3]);
            seed[2*i+1] = d.neg;
        end
    end

    // Per-cycle row generation and compression
    logic [YW:0]  y_q_ext;
    logic [2:0]   cur_trip;
    logic [W-1:0] row_m, row_c, cmp_s, cmp_c;
    logic [W-1:0] fa_sum;
    logic [NF_OUT-1:0] fa_cy;

    assign y_q_ext  = {ymul_q, 1'b0};
    assign cur_trip = y_q_ext[{row_q, 1'b0} +: 3];

    pcs_booth_row #(.W(W), .RW(RW)) u_row (
        .trip (cur_trip),
        .row  (row_q),
        .xm   (xm_q),
        .xc   (xc_q),
        .pm   (row_m),
        .pc   (row_c)
    );

    pcs_csa42 #(.W(W)) u_cmp (
        .in0 (acc_s),
        .in1 (acc_c),
        .in2 (row_m),
        .in3 (row_c),
        .sum (cmp_s),
        .cry (cmp_c)
    );

    pcs_frag_adder #(.W(W), .K(K)) u_fadd (
        .op_s (acc_s),
        .op_c (acc_c),
        .sum  (fa_sum),
        .fcy  (fa_cy)
    );

    logic last_row;
    assign last_row = (row_q == RW'(ROWS - 1));

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (start) state_nx = S_ACCUM;
            S_ACCUM:   if (last_row) state_nx = S_RESOLVE;
            S_RESOLVE: state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q   <= '0;
            ymul_q  <= '0;
            xm_q    <= '0;
            xc_q    <= '0;
            acc_s   <= '0;
            acc_c   <= '0;
            p_valid <= 1'b0;
            p_word  <= '0;
            p_frag  <= '0;
        end else begin
            p_valid <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        ymul_q <= y_in;
                        xm_q   <= a_ext;
                        xc_q   <= a_spread;
                        acc_s  <= seed;
                        acc_c  <= '0;
                        row_q  <= '0;
                    end
                end
                S_ACCUM: begin
                    acc_s <= cmp_s;
                    acc_c <= cmp_c;
                    row_q <= row_q + RW'(1);
                end
                S_RESOLVE: begin
                    p_word  <= fa_sum;
                    p_frag  <= fa_cy;
                    p_valid <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pcs_booth_mul_chk.sv
module pcs_booth_mul_chk #(
    parameter int N = 16,
    parameter int K = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [N-1:0]     a_word,
    input logic [N/K-1:0]   a_frag,
    input logic [N-1:0]     b_word,
    input logic [N/K-1:0]   b_frag,
    input logic             p_valid,
    input logic [2*N-1:0]   p_word,
    input logic [2*N/K-1:0] p_frag
);

    localparam int W     = 2 * N;
    localparam int ROWS  = (N + 2) / 2;
    localparam int DONE  = ROWS + 2;

    logic [7:0]   cnt;
    logic [W-1:0] cur_a, cur_b, exp_p, res_p;

    always_comb begin
        cur_a = {{(W-N){a_word[N-1]}}, a_word};
        cur_b = {{(W-N){b_word[N-1]}}, b_word};
        for (int j = 0; j < N / K; j++) begin
            if (a_frag[j]) cur_a = cur_a + (W'(1) << (j * K));
            if (b_frag[j]) cur_b = cur_b + (W'(1) << (j * K));
        end
        res_p = p_word;
        for (int j = 0; j < W / K; j++) begin
            if (p_frag[j]) res_p = res_p + (W'(1) << (j * K));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            exp_p <= '0;
        end else if (start && (cnt == 8'd0 || cnt == 8'(DONE))) begin
            cnt   <= 8'd1;
            exp_p <= cur_a * cur_b;
        end else if (cnt == 8'(DONE)) begin
            cnt <= '0;
        end else if (cnt != 8'd0) begin
            cnt <= cnt + 8'd1;
        end
    end

    p_valid_on_time_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == 8'(DONE)) |-> p_valid);

    p_no_stray_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        p_valid |-> (cnt == 8'(DONE)));

    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        p_valid |=> !p_valid);

    p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !p_valid |-> ($stable(p_word) && $stable(p_frag)));

    p_product_r2: assert property (@(posedge clk) disable iff (!rst_n)
        p_valid |-> (res_p == exp_p));

endmodule

bind pcs_booth_mul pcs_booth_mul_chk #(.N(N), .K(K)) u_pcs_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .a_word  (a_word),
    .a_frag  (a_frag),
    .b_word  (b_word),
    .b_frag  (b_frag),
    .p_valid (p_valid),
    .p_word  (p_word),
    .p_frag  (p_frag)
);

// File: tb/tb_pcs_booth_mul.sv
`timescale 1ns/1ps
module tb_pcs_booth_mul;

    localparam int N    = 16;
    localparam int K    = 4;
    localparam int NFI  = N / K;
    localparam int W    = 2 * N;
    localparam int NFO  = W / K;
    localparam int MDONE = N / 2 + 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [N-1:0]   a_word = '0, b_word = '0;
    logic [NFI-1:0] a_frag = '0, b_frag = '0;
    logic           p_valid;
    logic [W-1:0]   p_word;
    logic [NFO-1:0] p_frag;

    int checks = 0;
    int errors = 0;
    bit run_checks = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pcs_booth_mul #(.N(N), .K(K)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_word(a_word), .a_frag(a_frag), .b_word(b_word), .b_frag(b_frag),
        .p_valid(p_valid), .p_word(p_word), .p_frag(p_frag)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R1: operand value is signed main word plus weighted pending carries, exact
    function automatic logic [W-1:0] ref_prod(logic [N-1:0] am, logic [NFI-1:0] af,
                                              logic [N-1:0] bm, logic [NFI-1:0] bf);
        longint va, vb, p;
        va = longint'($signed(am));
        vb = longint'($signed(bm));
        for (int j = 0; j < NFI; j++) begin
            if (af[j]) va += longint'(1) << (j * K);
            if (bf[j]) vb += longint'(1) << (j * K);
        end
        p = va * vb;
        return p[W-1:0];
    endfunction

    function automatic logic [W-1:0] resolve(logic [W-1:0] wd, logic [NFO-1:0] fr);
        logic [W-1:0] r;
        r = wd;
        for (int j = 0; j < NFO; j++) if (fr[j]) r = r + (W'(1) << (j * K));
        return r;
    endfunction

    // Behavioural reference: acceptance, latency and expected results
    int           m_cnt = 0;
    bit           m_valid = 1'b0;
    logic [W-1:0] m_exp = '0;
    logic [W-1:0] exp_q[$];
    logic [W-1:0] last_word = '0;
    logic [NFO-1:0] last_frag = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0;
            m_valid = 1'b0;
            exp_q.delete();
        end else begin
            m_valid = 1'b0;
            if (m_cnt == 0) begin
                if (start) begin
                    exp_q.push_back(ref_prod(a_word, a_frag, b_word, b_frag));
                    m_cnt = 1;
                end
            end else begin
                m_cnt++;
                if (m_cnt == MDONE) begin
                    m_valid = 1'b1;
                    m_exp = exp_q.pop_front();
                    m_cnt = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && run_checks && !finished) begin
            chk(p_valid == m_valid, "R4,R5,R6,R9 valid timing", 64'(p_valid), 64'(m_valid));
            chk(p_frag[0] == 1'b0, "R3 lowest output carry", 64'(p_frag[0]), 64'd0);
            if (m_valid) begin
                chk(resolve(p_word, p_frag) == m_exp, "R1,R2 resolved product",
                    64'(resolve(p_word, p_frag)), 64'(m_exp));
                last_word = p_word;
                last_frag = p_frag;
            end else begin
                chk(p_word == last_word && p_frag == last_frag, "R7 output hold",
                    {p_frag, p_word}, {last_frag, last_word});
            end
        end
    end

    task automatic issue(input logic [N-1:0] am, input logic [NFI-1:0] af,
                         input logic [N-1:0] bm, input logic [NFI-1:0] bf, input int noise);
        @(negedge clk);
        a_word = am; a_frag = af; b_word = bm; b_frag = bf;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R6: starts with other operands while busy must be ignored
        for (int i = 0; i < noise; i++) begin
            @(negedge clk);
            a_word = N'($urandom); b_word = N'($urandom);
            a_frag = NFI'($urandom); b_frag = NFI'($urandom);
            start = 1'b1;
        end
        @(negedge clk);
        start = 1'b0;
        while (!p_valid) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        chk(p_valid == 1'b0, "R8 reset valid", 64'(p_valid), 64'd0);
        chk(p_word == '0, "R8 reset word", 64'(p_word), 64'd0);
        chk(p_frag == '0, "R8 reset frag", 64'(p_frag), 64'd0);
        run_checks = 1'b1;

        // R2 corner operands, with and without pending carries (R1)
        issue(16'h0000, 4'h0, 16'h0000, 4'h0, 0);
        issue(16'h0001, 4'h0, 16'h0001, 4'h0, 0);
        issue(16'hFFFF, 4'h0, 16'hFFFF, 4'h0, 0);
        issue(16'h8000, 4'h0, 16'h8000, 4'h0, 0);
        issue(16'h7FFF, 4'hF, 16'h7FFF, 4'hF, 0);
        issue(16'h8000, 4'hF, 16'h0001, 4'h0, 0);
        issue(16'h0000, 4'hF, 16'h8000, 4'hF, 3);
        issue(16'hFFFF, 4'hF, 16'hFFFF, 4'hF, 9);
        issue(16'h1234, 4'h5, 16'hEDCB, 4'hA, 5);

        // Random operands with sparse carries, some with busy-time starts
        for (int t = 0; t < 200; t++) begin
            issue(N'($urandom), NFI'($urandom & $urandom),
                  N'($urandom), NFI'($urandom & $urandom), t % 10);
        end

        // R9: start held high, operands changing every cycle
        @(negedge clk);
        for (int t = 0; t < 60; t++) begin
            a_word = N'($urandom); b_word = N'($urandom);
            a_frag = NFI'($urandom & $urandom); b_frag = NFI'($urandom & $urandom);
            start = 1'b1;
            @(negedge clk);
        end
        start = 1'b0;
        repeat (2 * MDONE) @(negedge clk);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule